// File: doc/BRIEF.md
# Grouped pin-change interrupt controller

This block watches 24 general-purpose input pins, arranged as three groups of up to eight, and raises one interrupt request line per group. Every pin is first passed through a two-flop synchronizer, and a change is detected by comparing the synchronized level with its sample from the previous cycle. Both rising and falling transitions count. A transition on a pin whose mask bit is one sets that group's sticky flag. The flag is shared by all pins of the group.

Software reaches the block through a small register bus. The bus has a 3-bit address, a one-cycle write strobe and combinational read data. The bus has no handshake: a write takes effect at the clock edge where the strobe is high, and the bus never stalls. There are no data streams, so no valid/ready interface is needed.

A flag clears when the interrupt-vector logic pulses the group's acknowledge input, or when software writes a one to the flag's bit. A request line is the group flag gated by the group enable bit and by a global interrupt-enable input.

Top module: `pcirq_top`

## Requirements
- R1: After reset the enable register, the flag register, all three mask registers and all three request outputs are zero.
- R2: Register addresses are as follows: 0 is the enable register (bit g enables group g), 1 is the flag register (bit g is group g's flag), and 2, 3 and 4 are the masks of groups 0, 1 and 2. In the enable and flag registers, bits 7..3 read as zero and ignore writes.
- R3: A rising or falling transition on an unmasked pin sets its group flag. The flag reads as one three clock edges after the pin changes.
- R4: A transition on a pin whose mask bit is zero leaves every flag unchanged.
- R5: Group 0 is pins 7..0 (mask bit i is pin i). Group 1 is pins 14..8 (mask bit i is pin 8+i). Group 2 is pins 23..16 (mask bit i is pin 16+i). Pin 15 belongs to no group: mask bit 7 at address 3 reads zero and ignores writes, and a change on pin 15 sets no flag.
- R6: Request output g is high exactly when flag g, enable bit g and the global interrupt-enable input are all one.
- R7: A flag is set by pin changes even while its group enable bit is zero.
- R8: A one on acknowledge input g clears flag g at the next clock edge.
- R9: Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves that flag unchanged.
- R10: If a new change and a clear (acknowledge or write-one) reach the same group in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 24 | Watched pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| ack_i | input | 3 | Per-group interrupt acknowledge pulse |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
A pin change passes through the synchronizer, then the previous-sample register, then the flag. The flag is therefore visible on the third rising edge after the pin is driven. The bench drives pins on a falling edge, waits three rising edges, and reads on the next falling edge. Register writes, acknowledges and write-one clears show on the edge that takes them. Read data and request lines are combinational from register state, so they are sampled one nanosecond after a falling edge. The same-cycle race of R10 is built by raising the acknowledge on the falling edge between the second and third rising edge after a pin change.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int unsigned GROUPS  = 3;
  localparam int unsigned GROUP_W = 8;
  localparam int unsigned PINS    = GROUPS * GROUP_W;
  localparam int unsigned AW      = 3;
  localparam int unsigned DW      = 8;

  localparam logic [AW-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [AW-1:0] ADDR_FLAG  = 3'd1;
  localparam logic [AW-1:0] ADDR_MASK0 = 3'd2;

  // pin 15 does not exist
  localparam logic [PINS-1:0] PIN_PRESENT = 24'hFF7FFF;
endpackage

// File: rtl/pcirq_edge.sv
module pcirq_edge #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign chg_o = sync_q ^ prev_q;
endmodule

// File: rtl/pcirq_group.sv
module pcirq_group #(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] chg_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  input  logic         ack_i,
  input  logic         en_i,
  input  logic         gie_i,
  output logic [W-1:0] mask_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         flag_q;
  logic         set_evt;

  assign set_evt = |(chg_i & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_wr_i) mask_q <= wdata_i & PRESENT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (ack_i || clr_i) flag_q <= 1'b0;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i & gie_i;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_evt) |=> !flag_q);
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack_i && !clr_i) |=> flag_q);
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && ((chg_i & mask_q) == '0)) |=> !flag_q);
endmodule

// File: rtl/pcirq_top.sv
module pcirq_top
  import pcirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic            gie_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_wr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [GROUPS-1:0] ack_i,
  output logic [GROUPS-1:0] irq_o
);
  logic [PINS-1:0]    chg;
  logic [GROUPS-1:0]  en_q;
  logic [GROUPS-1:0]  flags;
  logic [GROUP_W-1:0] mask_rd [GROUPS];
  logic               wr_ctrl, wr_flag;

  assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign wr_flag = bus_wr_i && (bus_addr_i == ADDR_FLAG);

  pcirq_edge #(.W(PINS)) i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .chg_o(chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_ctrl) en_q <= bus_wdata_i[GROUPS-1:0];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [AW-1:0] MASK_ADDR = ADDR_MASK0 + AW'(g);
    pcirq_group #(
      .W      (GROUP_W),
      .PRESENT(PIN_PRESENT[g*GROUP_W +: GROUP_W])
    ) i_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .chg_i    (chg[g*GROUP_W +: GROUP_W]),
      .mask_wr_i(bus_wr_i && (bus_addr_i == MASK_ADDR)),
      .wdata_i  (bus_wdata_i[GROUP_W-1:0]),
      .clr_i    (wr_flag && bus_wdata_i[g]),
      .ack_i    (ack_i[g]),
      .en_i     (en_q[g]),
      .gie_i    (gie_i),
      .mask_o   (mask_rd[g]),
      .flag_o   (flags[g]),
      .irq_o    (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_CTRL) bus_rdata_o = DW'(en_q);
    else if (bus_addr_i == ADDR_FLAG) bus_rdata_o = DW'(flags);
    else begin
      for (int g = 0; g < GROUPS; g++) begin
        if (bus_addr_i == ADDR_MASK0 + AW'(g)) bus_rdata_o = DW'(mask_rd[g]);
      end
    end
  end

  a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> gie_i);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr_i == ADDR_CTRL) || (bus_addr_i == ADDR_FLAG)) |-> (bus_rdata_o[DW-1:GROUPS] == '0));
  a_r5_no_pin15_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_MASK0 + AW'(1)) |-> !bus_rdata_o[7]);
endmodule

// File: tb/test_pcirq_top.sv
module test_pcirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_i = '0;
  logic        gie_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [2:0]  ack_i = '0;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pcirq_top i_pcirq_top (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .ack_i(ack_i), .irq_o(irq_o)
  );

  // {pins, expected flag register}, masks: g0=FF, g1=7F, g2=0F
  localparam logic [31:0] VEC [8] = '{
    {24'h000001, 8'h01},
    {24'h000000, 8'h01},
    {24'h000100, 8'h02},
    {24'h008100, 8'h00},
    {24'h018100, 8'h04},
    {24'h118100, 8'h00},
    {24'h000000, 8'h06},
    {24'h800080, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk);
    #1 bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr_i = a;
    #1 v = bus_rdata_o;
  endtask

  task automatic drive_pins(input logic [23:0] p);
    @(negedge clk);
    pin_i = p;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 reset reg", v, 8'h00);
    end
    gie_i = 1'b1;
    #1 check("R1 reset irq", {5'b0, irq_o}, 8'h00);
    gie_i = 1'b0;

    // R2 reserved bits; R5 pin 15 mask bit
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R2 ctrl reserved", v, 8'h07);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h0F);
    rd(3'd3, v); check("R5 mask1 bit7", v, 8'h7F);
    rd(3'd4, v); check("R2 mask2 readback", v, 8'h0F);

    // table: R3 both edges, R4 masked, R5 group membership, R7 with enables off
    foreach (VEC[i]) begin
      drive_pins(VEC[i][31:8]);
      rd(3'd1, v);
      check($sformatf("R3/R4/R5/R7 vector %0d", i), v, VEC[i][7:0]);
      wr(3'd1, 8'hFF);
      rd(3'd1, v);
      check("R2 flag reserved / clear", v, 8'h00);
    end

    // R6 gating
    drive_pins(24'h800000);              // pin7 falls -> g0 flag
    wr(3'd0, 8'h01);
    @(negedge clk); #1 check("R6 gie low", {5'b0, irq_o}, 8'h00);
    gie_i = 1'b1;
    #1 check("R6 request", {5'b0, irq_o}, 8'h01);
    wr(3'd0, 8'h00);
    @(negedge clk); #1 check("R6 enable low", {5'b0, irq_o}, 8'h00);
    rd(3'd1, v); check("R7 flag kept with enable low", v, 8'h01);

    // R8 acknowledge
    @(negedge clk); ack_i = 3'b001;
    @(negedge clk); ack_i = 3'b000;
    rd(3'd1, v); check("R8 ack clears", v, 8'h00);

    // R9 write-one clears only its bit
    drive_pins(24'h010100);              // pin8 (g1), pin16 (g2)
    rd(3'd1, v); check("R9 setup", v, 8'h06);
    wr(3'd1, 8'h02);
    rd(3'd1, v); check("R9 write one/zero", v, 8'h04);
    wr(3'd1, 8'h04);

    // R10 set beats simultaneous ack
    drive_pins(24'h010101);
    rd(3'd1, v); check("R10 setup", v, 8'h01);
    @(negedge clk); pin_i = 24'h010100;  // pin0 falls
    repeat (2) @(posedge clk);
    @(negedge clk); ack_i = 3'b001;
    @(negedge clk); ack_i = 3'b000;
    rd(3'd1, v); check("R10 set wins over ack", v, 8'h01);

    // R10 set beats simultaneous write-one
    @(negedge clk); pin_i = 24'h010101;
    repeat (2) @(posedge clk);
    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R10 set wins over write", v, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule